// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block sits on the processor side of an interrupt system. It watches the level of the highest pending interrupt request and compares it with the current priority mask. When the request outranks the mask and the core reports a point where it can be interrupted, the block takes the request through a fixed order of phases. First a state-save phase of a set length runs. Then a one-cycle strobe clears the program-counter extension field. Last comes an acknowledge bus cycle in CPU space, whose address carries the priority being acknowledged.

During the acknowledge cycle the new mask value is taken from bits 3:1 of the address being driven. A single-cycle write strobe pushes it to the condition-code logic, so lower levels stay blocked while the exception is handled. The cycle can end in four ways: a responder supplies a vector, the bus reports an error, the responder's arbitration ID is zero, or the response window runs out. In every case except the first, the block hands on a fixed spurious vector and raises a one-cycle spurious flag.

Top module: `irq_ack_seq`

## Requirements
- R1: A sequence starts from idle only in a cycle where `insn_bound` is 1 and `req_level` is strictly greater than `ipl_mask`. Otherwise the block stays idle with `save_busy` at 0.
- R2: After the start, `save_busy` is 1 for exactly SAVE_CYCLES cycles. Then `pk_clr` is 1 for exactly one cycle, and the acknowledge cycle begins in the next cycle.
- R3: While the acknowledge cycle runs, `fc` is 3'b111 and `addr` is {20 ones, level, 1'b1}, with the level in bits 3:1. At all other times `fc` is 3'b000 and `addr` is zero.
- R4: `mask_wr` pulses for one cycle, in the first acknowledge cycle only. In that cycle `mask_new` equals `addr[3:1]`.
- R5: If `ack_dvalid` is 1 with a nonzero `ack_src_id` and `ack_berr` is 0 during an acknowledge cycle, the next cycle shows `vec_valid`=1, `vec_out`=`ack_vector` and `spurious`=0.
- R6: If `ack_berr` is 1 during an acknowledge cycle, the next cycle shows `vec_valid`=1, `spurious`=1 and `vec_out`=SPUR_VEC (default 24). This holds even when `ack_dvalid` is also 1.
- R7: If `ack_dvalid` is 1 with `ack_src_id` equal to 0, the outcome is spurious, as in R6.
- R8: If no response arrives, the acknowledge cycle lasts exactly TIMEOUT cycles, counted from the first cycle the address is driven. A spurious outcome follows. A response in the last allowed cycle is still accepted.
- R9: Changes on `req_level`, `ipl_mask`, `insn_bound` and the bus response inputs outside the acknowledge cycle do not affect a running sequence. The acknowledged level is the one captured at the start.
- R10: `vec_valid` and `spurious` last one cycle, after which the block is idle and may start a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_level | input | 3 | Level of the highest pending request |
| ipl_mask | input | 3 | Current interrupt priority mask |
| insn_bound | input | 1 | Core is at a point where it can be interrupted |
| ack_dvalid | input | 1 | Responder terminates the cycle with a vector |
| ack_vector | input | 8 | Vector number from the responder |
| ack_src_id | input | 4 | Arbitration ID of the responder |
| ack_berr | input | 1 | Bus error terminates the cycle |
| fc | output | 3 | Function code (3'b111 = CPU space) |
| addr | output | 24 | Acknowledge address |
| save_busy | output | 1 | State-save phase active |
| pk_clr | output | 1 | Clear the program-counter extension field |
| mask_wr | output | 1 | Write strobe for the priority mask |
| mask_new | output | 3 | New mask value taken from the address |
| vec_valid | output | 1 | Vector handed on this cycle |
| vec_out | output | 8 | Vector number handed on |
| spurious | output | 1 | Outcome is a spurious interrupt |

## Verification
The hardest case to reach from the ports is the edge of the timeout window. The window can end with a response that lands exactly in its last allowed cycle, or with no response at all, so the window runs out exactly once. The stimulus reaches it by choosing the response delay at random over a range that includes both TIMEOUT-1 and a value past the window. It also uses directed runs for both edges. Throughout the save and acknowledge phases, the request, mask, boundary and stray bus inputs are scrambled, so a captured level that leaked or a restart would show up.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam int LVL_W  = 3;
  localparam int ADDR_W = 24;
  localparam int ID_W   = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SAVE = 3'd1,
    ST_XCLR = 3'd2,
    ST_ACK  = 3'd3,
    ST_DONE = 3'd4
  } iack_state_e;

  localparam logic [2:0] FC_NONE      = 3'b000;
  localparam logic [2:0] FC_CPU_SPACE = 3'b111;

  // acknowledge address: all ones above the level field, level in [3:1], bit 0 set
  function automatic logic [ADDR_W-1:0] ack_address(input logic [LVL_W-1:0] lvl);
    ack_address = {{(ADDR_W-LVL_W-1){1'b1}}, lvl, 1'b1};
  endfunction
endpackage

// File: rtl/iack_rst_sync.sv
module iack_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/iack_qualify.sv
module iack_qualify
  import iack_pkg::*;
(
  input  logic [LVL_W-1:0] req_level,
  input  logic [LVL_W-1:0] ipl_mask,
  input  logic             insn_bound,
  input  logic             idle,
  output logic             start
);
  always_comb begin
    start = idle && insn_bound && (req_level > ipl_mask);
  end
endmodule

// File: rtl/iack_cycle_cnt.sv
module iack_cycle_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic first,
  output logic last
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = run || (cnt_q != '0);
    cnt_d  = run ? (cnt_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign first = run && (cnt_q == '0);
  assign last  = run && (cnt_q == LAST_VAL);
endmodule

// File: rtl/iack_resp.sv
module iack_resp
  import iack_pkg::*;
#(
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'd24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_active,
  input  logic             window_last,
  input  logic             ack_dvalid,
  input  logic [VEC_W-1:0] ack_vector,
  input  logic [ID_W-1:0]  ack_src_id,
  input  logic             ack_berr,
  output logic             done,
  output logic [VEC_W-1:0] vec_q,
  output logic             spur_q
);
  logic             spur_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    done   = ack_active && (ack_berr || ack_dvalid || window_last);
    spur_d = 1'b1;
    vec_d  = SPUR_VEC;
    if (!ack_berr && ack_dvalid && (ack_src_id != '0)) begin
      spur_d = 1'b0;
      vec_d  = ack_vector;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      spur_q <= 1'b0;
    end else if (done) begin
      vec_q  <= vec_d;
      spur_q <= spur_d;
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import iack_pkg::*;
#(
  parameter int         SAVE_CYCLES = 4,
  parameter int         TIMEOUT     = 16,
  parameter logic [7:0] SPUR_VEC    = 8'd24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  req_level,
  input  logic [2:0]  ipl_mask,
  input  logic        insn_bound,
  input  logic        ack_dvalid,
  input  logic [7:0]  ack_vector,
  input  logic [3:0]  ack_src_id,
  input  logic        ack_berr,
  output logic [2:0]  fc,
  output logic [23:0] addr,
  output logic        save_busy,
  output logic        pk_clr,
  output logic        mask_wr,
  output logic [2:0]  mask_new,
  output logic        vec_valid,
  output logic [7:0]  vec_out,
  output logic        spurious
);
  localparam int VEC_W = 8;

  logic             rst_sync_n;
  iack_state_e      state_q, state_d;
  logic [LVL_W-1:0] lvl_q;
  logic             lvl_en;
  logic             start;
  logic             save_last, save_first_unused;
  logic             ack_first, ack_last;
  logic             resp_done;
  logic [VEC_W-1:0] res_vec;
  logic             res_spur;
  logic             in_ack;

  iack_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  iack_qualify u_qual (
    .req_level  (req_level),
    .ipl_mask   (ipl_mask),
    .insn_bound (insn_bound),
    .idle       (state_q == ST_IDLE),
    .start      (start)
  );

  iack_cycle_cnt #(.LIMIT(SAVE_CYCLES)) u_save_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (state_q == ST_SAVE),
    .first (save_first_unused),
    .last  (save_last)
  );

  iack_cycle_cnt #(.LIMIT(TIMEOUT)) u_tmo_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (in_ack),
    .first (ack_first),
    .last  (ack_last)
  );

  iack_resp #(.VEC_W(VEC_W), .SPUR_VEC(SPUR_VEC)) u_resp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ack_active  (in_ack),
    .window_last (ack_last),
    .ack_dvalid  (ack_dvalid),
    .ack_vector  (ack_vector),
    .ack_src_id  (ack_src_id),
    .ack_berr    (ack_berr),
    .done        (resp_done),
    .vec_q       (res_vec),
    .spur_q      (res_spur)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    lvl_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SAVE;
        lvl_en  = 1'b1;
      end
      ST_SAVE: if (save_last) state_d = ST_XCLR;
      ST_XCLR: state_d = ST_ACK;
      ST_ACK:  if (resp_done) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
    end else begin
      state_q <= state_d;
      if (lvl_en) lvl_q <= req_level;
    end
  end

  // outputs
  always_comb begin
    in_ack    = (state_q == ST_ACK);
    fc        = in_ack ? FC_CPU_SPACE : FC_NONE;
    addr      = in_ack ? ack_address(lvl_q) : '0;
    save_busy = (state_q == ST_SAVE);
    pk_clr    = (state_q == ST_XCLR);
    mask_wr   = ack_first;
    mask_new  = addr[3:1];
    vec_valid = (state_q == ST_DONE);
    vec_out   = vec_valid ? res_vec : '0;
    spurious  = vec_valid && res_spur;
  end
endmodule

// File: rtl/iack_checker.sv
module iack_checker #(
  parameter int         TIMEOUT  = 16,
  parameter logic [7:0] SPUR_VEC = 8'd24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_berr,
  input logic [2:0]  fc,
  input logic [23:0] addr,
  input logic        save_busy,
  input logic        pk_clr,
  input logic        mask_wr,
  input logic [2:0]  mask_new,
  input logic        vec_valid,
  input logic [7:0]  vec_out,
  input logic        spurious
);
  localparam int CW = $clog2(TIMEOUT + 2);
  logic [CW-1:0] ack_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ack_run <= '0;
    else if (fc == 3'b111)  ack_run <= ack_run + 1'b1;
    else                    ack_run <= '0;
  end

  assert_addr_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc == 3'b111) |-> (addr[23:4] == 20'hFFFFF && addr[0] == 1'b1));

  assert_idle_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc != 3'b111) |-> (fc == 3'b000 && addr == 24'd0));

  assert_mask_from_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |-> (fc == 3'b111 && mask_new == addr[3:1]));

  assert_clr_then_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pk_clr |=> (fc == 3'b111 && mask_wr));

  assert_save_before_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pk_clr) |-> $past(save_busy));

  assert_berr_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fc == 3'b111 && ack_berr) |=> (spurious && vec_out == SPUR_VEC));

  assert_spur_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> (vec_valid && vec_out == SPUR_VEC));

  assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fc == 3'b111) |-> (ack_run < CW'(TIMEOUT)));

  assert_one_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_busy, pk_clr, fc == 3'b111, vec_valid}));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
endmodule

bind irq_ack_seq iack_checker #(.TIMEOUT(TIMEOUT), .SPUR_VEC(SPUR_VEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack_berr  (ack_berr),
  .fc        (fc),
  .addr      (addr),
  .save_busy (save_busy),
  .pk_clr    (pk_clr),
  .mask_wr   (mask_wr),
  .mask_new  (mask_new),
  .vec_valid (vec_valid),
  .vec_out   (vec_out),
  .spurious  (spurious)
);

// File: tb/sim_irq_ack_seq.sv
`timescale 1ns/1ps
module sim_irq_ack_seq;
  localparam int         SAVE_CYCLES = 4;
  localparam int         TIMEOUT     = 16;
  localparam logic [7:0] SPUR_VEC    = 8'd24;
  // response kinds
  localparam int K_VEC = 0, K_BERR = 1, K_ID0 = 2, K_BOTH = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  req_level, ipl_mask;
  logic        insn_bound, ack_dvalid, ack_berr;
  logic [7:0]  ack_vector;
  logic [3:0]  ack_src_id;
  logic [2:0]  fc, mask_new;
  logic [23:0] addr;
  logic        save_busy, pk_clr, mask_wr, vec_valid, spurious;
  logic [7:0]  vec_out;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_ack_seq #(.SAVE_CYCLES(SAVE_CYCLES), .TIMEOUT(TIMEOUT), .SPUR_VEC(SPUR_VEC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_level(req_level), .ipl_mask(ipl_mask),
    .insn_bound(insn_bound), .ack_dvalid(ack_dvalid), .ack_vector(ack_vector),
    .ack_src_id(ack_src_id), .ack_berr(ack_berr), .fc(fc), .addr(addr),
    .save_busy(save_busy), .pk_clr(pk_clr), .mask_wr(mask_wr), .mask_new(mask_new),
    .vec_valid(vec_valid), .vec_out(vec_out), .spurious(spurious));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] exp_addr(input logic [2:0] lvl);
    return {20'hFFFFF, lvl, 1'b1};
  endfunction

  function automatic logic exp_spur(input int kind, input int delay);
    if (delay >= TIMEOUT) return 1'b1;
    return (kind != K_VEC);
  endfunction

  task automatic scramble();
    req_level  = 3'($urandom);
    ipl_mask   = 3'($urandom);
    insn_bound = 1'($urandom);
  endtask

  // one full sequence; delay >= TIMEOUT means no response at all
  task automatic run_seq(input logic [2:0] lvl, input logic [2:0] msk, input int kind,
                         input int delay, input logic [7:0] vec);
    logic sp;
    int k;
    req_level = lvl; ipl_mask = msk; insn_bound = 1'b1;
    @(negedge clk);
    for (int i = 0; i < SAVE_CYCLES; i++) begin
      scramble();
      ack_dvalid = 1'($urandom); ack_berr = 1'($urandom); ack_src_id = 4'($urandom);
      chk(save_busy && !pk_clr && fc == 3'b000, "R2 save", {save_busy, pk_clr, fc}, 5'b10000);
      @(negedge clk);
    end
    ack_dvalid = 1'b0; ack_berr = 1'b0;
    chk(pk_clr && !save_busy && fc == 3'b000, "R2 clear", {save_busy, pk_clr, fc}, 5'b01000);
    scramble();
    @(negedge clk);
    k = 0;
    forever begin
      chk(fc == 3'b111, "R3 fc", fc, 3'b111);
      chk(addr == exp_addr(lvl), "R9 R3 addr", addr, exp_addr(lvl));
      chk(mask_wr == (k == 0), "R4 strobe", mask_wr, (k == 0));
      if (k == 0) chk(mask_new == lvl, "R4 mask", mask_new, lvl);
      scramble();
      if (k == delay) begin
        ack_vector = vec;
        ack_src_id = (kind == K_ID0) ? 4'd0 : 4'(1 + $urandom % 15);
        ack_dvalid = (kind != K_BERR);
        ack_berr   = (kind == K_BERR || kind == K_BOTH);
      end
      @(negedge clk);
      ack_dvalid = 1'b0; ack_berr = 1'b0;
      if (k == delay || k == TIMEOUT - 1) break;
      k++;
    end
    sp = exp_spur(kind, delay);
    chk(vec_valid, "R5 valid", vec_valid, 1);
    chk(spurious == sp, "R6 R7 R8 spurious", spurious, sp);
    chk(vec_out == (sp ? SPUR_VEC : vec), "R5 R6 vector", vec_out, sp ? SPUR_VEC : vec);
    if (delay >= TIMEOUT) chk(k == TIMEOUT - 1, "R8 window", k, TIMEOUT - 1);
    req_level = 3'd0; insn_bound = 1'b0;
    @(negedge clk);
    chk(!vec_valid && !spurious && !save_busy && fc == 3'b000, "R10 idle",
        {vec_valid, spurious, save_busy, fc}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [2:0] l, m;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_level = 0; ipl_mask = 0; insn_bound = 0;
    ack_dvalid = 0; ack_berr = 0; ack_vector = 0; ack_src_id = 0;
    repeat (3) @(negedge clk);
    chk(fc == 0 && addr == 0 && !save_busy && !vec_valid && !mask_wr, "R3 reset",
        {fc, save_busy, vec_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: level not above mask, or no boundary -> stays idle
    req_level = 3'd3; ipl_mask = 3'd3; insn_bound = 1'b1;
    repeat (2) begin @(negedge clk); chk(!save_busy, "R1 equal", save_busy, 0); end
    req_level = 3'd7; ipl_mask = 3'd0; insn_bound = 1'b0;
    repeat (2) begin @(negedge clk); chk(!save_busy, "R1 no boundary", save_busy, 0); end
    req_level = 3'd2; ipl_mask = 3'd5; insn_bound = 1'b1;
    repeat (2) begin @(negedge clk); chk(!save_busy, "R1 below", save_busy, 0); end
    req_level = 0; insn_bound = 0;
    @(negedge clk);

    // directed corners
    run_seq(3'd7, 3'd6, K_VEC, 0, 8'h40);             // R5 immediate
    run_seq(3'd1, 3'd0, K_VEC, TIMEOUT - 1, 8'h99);   // R8 last allowed cycle
    run_seq(3'd4, 3'd2, K_VEC, TIMEOUT + 3, 8'h11);   // R8 timeout
    run_seq(3'd5, 3'd1, K_BERR, 2, 8'h33);            // R6
    run_seq(3'd6, 3'd3, K_BOTH, 1, 8'h55);            // R6 berr wins
    run_seq(3'd2, 3'd1, K_ID0, 3, 8'h77);             // R7

    // R10: back-to-back start right after idle returns
    run_seq(3'd3, 3'd0, K_VEC, 5, 8'hA5);

    for (int n = 0; n < 200; n++) begin
      l = 3'(1 + $urandom % 7);
      m = 3'($urandom % l);
      run_seq(l, m, $urandom % 4, $urandom % (TIMEOUT + 4), 8'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule